// File: doc/BRIEF.md
# UART Receive Buffer Ring

This block sits behind a UART receiver and collects its bytes into a ring of fixed-size capture buffers held in an internal byte memory. Each buffer has a five-bit status word and a length count. A buffer closes when it fills, or when an idle timer runs out after the last character. Closing marks the buffer ready, emits a one-cycle ready event that carries the buffer index, and moves filling on to the next buffer in strict rotation.

Software sees the block through a control word, an idle limit, a status and length query port, a byte read port and a clear strobe. Clearing a buffer's status hands the buffer back to the ring. A buffer that is still marked ready is never overwritten. Bytes that arrive while the buffer being filled is still ready are dropped, and the loss is reported as an overrun. An abort bit freezes reception until the enable bit is cleared. Enabling again restarts at buffer 0.

Top module: `rxbuf_ring`

## Requirements
- R1: Control word fields: bit 0 is enable, bit 1 is abort, and bits 9:6 give the number of buffers in use. A value of 0 means one buffer, and a value above NUM_SLOTS means NUM_SLOTS.
- R2: Accepted bytes are stored at consecutive indices of the active buffer and can be read back through the read port. Buffers fill in the order 0, 1, … up to the count in use minus 1, then wrap to 0.
- R3: When a buffer receives its BUF_BYTES-th byte it closes. Its status bit 0 (ready) is set, bit 1 (expired) stays clear, its length becomes BUF_BYTES, and ready_evt pulses for one cycle with ready_slot equal to its index.
- R4: If the active buffer holds at least one byte and idle_limit tick pulses pass with no new byte, the buffer closes. Its status bits 0 and 1 are set and its length equals the bytes held. An idle_limit of 0 disables this close. A byte that arrives in the same cycle as the final tick wins: the buffer stays open and the tick count restarts.
- R5: Input flags rx_perr, rx_ferr and rx_oerr on an accepted byte set status bits 2, 3 and 4 of the active buffer. These bits remain set until the buffer is cleared.
- R6: A byte that arrives while the active buffer is still ready is dropped. The buffer's contents and the fill position do not change. The next byte that is accepted sets status bit 4 of the buffer it lands in.
- R7: A pulse on clr_valid zeroes the whole status word of clr_slot. If a close of that same buffer happens in the same cycle, the new status from the close is kept, and error flags from before the clear are gone.
- R8: Setting abort while the block is enabled and running gives exactly one abort_evt pulse. After that, bytes and ticks are ignored and no ready events occur until enable is cleared.
- R9: While enable is low, bytes are ignored, and the active buffer and fill count stay at 0. Enabling again starts filling at buffer 0, index 0.
- R10: After reset, all status words are 0, the active buffer and fill count are 0, and neither event output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 10 | Enable (0), abort (1), buffers in use (9:6) |
| idle_limit | input | IDLE_W | Ticks without a byte before an idle close; 0 disables |
| tick | input | 1 | Idle timer tick strobe |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error on this byte |
| rx_ferr | input | 1 | Framing error on this byte |
| rx_oerr | input | 1 | Receiver overrun on this byte |
| clr_valid | input | 1 | Clear status of clr_slot |
| clr_slot | input | SLOT_W | Buffer whose status is cleared |
| stat_slot | input | SLOT_W | Buffer to query |
| stat_word | output | 5 | Status of stat_slot: {ovr, ferr, perr, expired, ready} |
| stat_len | output | CNT_W | Length of stat_slot when it closed |
| rd_slot | input | SLOT_W | Buffer to read |
| rd_idx | input | IDX_W | Byte index to read |
| rd_data | output | 8 | Byte at rd_slot, rd_idx |
| active_slot | output | SLOT_W | Buffer being filled |
| fill_count | output | CNT_W | Bytes held in the active buffer |
| ready_evt | output | 1 | One-cycle pulse per closed buffer |
| ready_slot | output | SLOT_W | Index of the buffer that closed |
| abort_evt | output | 1 | One-cycle pulse on abort |

## Verification
Two pairs of events can land in the same cycle. The first is a received byte and the final idle tick. The bench drives them together after two ticks of a three-tick limit. It then expects no ready event, one more byte in the fill count, and an idle close only after three further ticks. The second pair is a clear and a close of the same buffer. The bench raises clr_valid on the cycle of the byte that fills the buffer. It expects a status of exactly ready, with the parity flag from earlier bytes removed.

// File: rtl/rxbuf_ring.sv
module rxbuf_ring #(
  parameter int NUM_SLOTS = 8,
  parameter int BUF_BYTES = 16,
  parameter int IDLE_W    = 16,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int IDX_W    = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [9:0]        ctrl_word,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic              tick,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_oerr,
  input  logic              clr_valid,
  input  logic [SLOT_W-1:0] clr_slot,
  input  logic [SLOT_W-1:0] stat_slot,
  output logic [4:0]        stat_word,
  output logic [CNT_W-1:0]  stat_len,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        rd_data,
  output logic [SLOT_W-1:0] active_slot,
  output logic [CNT_W-1:0]  fill_count,
  output logic              ready_evt,
  output logic [SLOT_W-1:0] ready_slot,
  output logic              abort_evt
);
  localparam int MEM_D  = NUM_SLOTS * BUF_BYTES;
  localparam int MEM_AW = (MEM_D > 1) ? $clog2(MEM_D) : 1;

  logic [7:0]        mem [MEM_D];
  logic [4:0]        stat [NUM_SLOTS];
  logic [4:0]        stat_nxt [NUM_SLOTS];
  logic [CNT_W-1:0]  len [NUM_SLOTS];
  logic [SLOT_W-1:0] active;
  logic [CNT_W-1:0]  cnt;
  logic [IDLE_W-1:0] timer;
  logic              halted, drop_ovr;

  wire       en   = ctrl_word[0];
  wire       abrt = ctrl_word[1];
  wire [3:0] fld  = ctrl_word[9:6];
  logic      unused_ctrl;
  assign unused_ctrl = ^ctrl_word[5:2];

  logic [3:0] n_use;
  assign n_use = (fld == 4'd0) ? 4'd1 : ((32'(fld) > NUM_SLOTS) ? 4'(NUM_SLOTS) : fld);

  wire run      = en && !halted && !abrt;
  wire act_rdy  = stat[active][0];
  wire take     = run && rx_valid && !act_rdy;
  wire drop     = run && rx_valid && act_rdy;
  wire full_cls = take && (32'(cnt) == BUF_BYTES - 1);
  wire timing   = run && !rx_valid && tick && (cnt != '0) && (idle_limit != '0);
  wire idle_cls = timing && (32'(timer) + 1 >= 32'(idle_limit));
  wire close    = full_cls || idle_cls;

  logic [SLOT_W-1:0] next_act;
  assign next_act = (32'(active) + 1 >= 32'(n_use)) ? '0 : active + 1'b1;

  wire [MEM_AW-1:0] wr_addr = MEM_AW'(32'(active) * BUF_BYTES + 32'(cnt));
  wire [MEM_AW-1:0] rd_addr = MEM_AW'(32'(rd_slot) * BUF_BYTES + 32'(rd_idx));

  assign rd_data     = mem[rd_addr];
  assign stat_word   = stat[stat_slot];
  assign stat_len    = len[stat_slot];
  assign active_slot = active;
  assign fill_count  = cnt;

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      stat_nxt[s] = (clr_valid && 32'(clr_slot) == s) ? 5'd0 : stat[s];
      if (32'(active) == s) begin
        if (take)  stat_nxt[s] = stat_nxt[s] | {rx_oerr | drop_ovr, rx_ferr, rx_perr, 2'b00};
        if (close) stat_nxt[s] = stat_nxt[s] | {3'b000, idle_cls, 1'b1};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) mem[wr_addr] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        stat[s] <= '0;
        len[s]  <= '0;
      end
      active     <= '0;
      cnt        <= '0;
      timer      <= '0;
      halted     <= 1'b0;
      drop_ovr   <= 1'b0;
      ready_evt  <= 1'b0;
      ready_slot <= '0;
      abort_evt  <= 1'b0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) stat[s] <= stat_nxt[s];
      ready_evt <= close;
      abort_evt <= en && abrt && !halted;
      if (close) begin
        ready_slot  <= active;
        len[active] <= full_cls ? CNT_W'(BUF_BYTES) : cnt;
      end
      if (!en) begin
        active   <= '0;
        cnt      <= '0;
        timer    <= '0;
        halted   <= 1'b0;
        drop_ovr <= 1'b0;
      end else if (abrt && !halted) begin
        halted <= 1'b1;
      end else if (run) begin
        if (take) begin
          timer    <= '0;
          drop_ovr <= 1'b0;
          if (full_cls) begin
            cnt    <= '0;
            active <= next_act;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (drop) begin
          drop_ovr <= 1'b1;
        end else if (idle_cls) begin
          cnt    <= '0;
          timer  <= '0;
          active <= next_act;
        end else if (timing) begin
          timer <= timer + 1'b1;
        end
      end
    end
  end

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < BUF_BYTES);
  assert_evt_marks_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready_evt |-> stat[ready_slot][0]);
  assert_full_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_evt && !stat[ready_slot][1]) |-> (32'(len[ready_slot]) == BUF_BYTES));
  assert_idle_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_evt && stat[ready_slot][1]) |-> (len[ready_slot] != '0 && 32'(len[ready_slot]) < BUF_BYTES));
  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> !ready_evt);
  assert_abort_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !abort_evt);
  assert_disabled_home_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && active == '0));
endmodule

// File: tb/rxbuf_ring_test.sv
module rxbuf_ring_test;
  localparam int NS = 8, BB = 4, IW = 8;
  localparam int SW = 3, XW = 2, CW = 3;

  logic clk = 0, rst_n = 0;
  logic [9:0] ctrl_word = '0;
  logic [IW-1:0] idle_limit = '0;
  logic tick = 0, rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_oerr = 0, clr_valid = 0;
  logic [7:0] rx_data = '0;
  logic [SW-1:0] clr_slot = '0, stat_slot = '0, rd_slot = '0;
  logic [XW-1:0] rd_idx = '0;
  logic [4:0] stat_word;
  logic [CW-1:0] stat_len, fill_count;
  logic [7:0] rd_data;
  logic [SW-1:0] active_slot, ready_slot;
  logic ready_evt, abort_evt;

  int checks = 0, fails = 0, evt_n = 0, evt_last = -1, ab_n = 0;

  rxbuf_ring #(.NUM_SLOTS(NS), .BUF_BYTES(BB), .IDLE_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .idle_limit(idle_limit), .tick(tick),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_oerr(rx_oerr),
    .clr_valid(clr_valid), .clr_slot(clr_slot), .stat_slot(stat_slot), .stat_word(stat_word),
    .stat_len(stat_len), .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_data(rd_data),
    .active_slot(active_slot), .fill_count(fill_count), .ready_evt(ready_evt),
    .ready_slot(ready_slot), .abort_evt(abort_evt));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    #2;
    if (ready_evt) begin evt_n++; evt_last = int'(ready_slot); end
    if (abort_evt) ab_n++;
  end

  function automatic logic [9:0] mk_ctrl(input int n, input bit en, input bit ab);
    return {4'(n), 4'b0000, ab, en};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input logic [7:0] d, input bit p = 0, input bit f = 0,
                     input bit o = 0, input bit tk = 0, input bit cl = 0, input int cs = 0);
    @(negedge clk);
    rx_valid = v; rx_data = d; rx_perr = p; rx_ferr = f; rx_oerr = o;
    tick = tk; clr_valid = cl; clr_slot = SW'(cs);
    @(negedge clk);
    rx_valid = 0; rx_perr = 0; rx_ferr = 0; rx_oerr = 0; tick = 0; clr_valid = 0;
  endtask

  task automatic peek(input int s, input string tag, input int st, input int ln);
    stat_slot = SW'(s); #1;
    chk({tag, " status"}, int'(stat_word), st);
    if (ln >= 0) chk({tag, " length"}, int'(stat_len), ln);
  endtask

  task automatic peek_byte(input int s, input int i, input string tag, input int exp);
    rd_slot = SW'(s); rd_idx = XW'(i); #1;
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic t_reset;
    peek(0, "R10 reset slot0", 0, 0);
    peek(7, "R10 reset slot7", 0, -1);
    chk("R10 reset active", int'(active_slot), 0);
    chk("R10 reset fill", int'(fill_count), 0);
    chk("R10 reset events", int'(ready_evt) + int'(abort_evt), 0);
  endtask

  task automatic t_full;
    ctrl_word = mk_ctrl(2, 1, 0);
    for (int i = 0; i < BB; i++) cyc(1, 8'hA0 + 8'(i));
    chk("R3 one ready event", evt_n, 1);
    chk("R3 ready slot", evt_last, 0);
    peek(0, "R3 full close", 5'b00001, BB);
    chk("R2 advance to slot1", int'(active_slot), 1);
    for (int i = 0; i < BB; i++) peek_byte(0, i, "R2 stored byte", 'hA0 + i);
  endtask

  task automatic t_idle;
    idle_limit = 3;
    cyc(1, 8'hB0); cyc(1, 8'hB1);
    cyc(0, 0, .tk(1)); cyc(0, 0, .tk(1));
    cyc(1, 8'hB2, .tk(1));
    chk("R4 byte beats final tick: no event", evt_n, 1);
    chk("R4 byte beats final tick: fill", int'(fill_count), 3);
    cyc(0, 0, .tk(1)); cyc(0, 0, .tk(1));
    chk("R4 not closed before limit", evt_n, 1);
    cyc(0, 0, .tk(1));
    chk("R4 idle close event", evt_n, 2);
    chk("R4 idle close slot", evt_last, 1);
    peek(1, "R4 idle close", 5'b00011, 3);
    chk("R2 wrap to slot0", int'(active_slot), 0);
    peek_byte(1, 2, "R2 idle buffer byte", 'hB2);
  endtask

  task automatic t_drop;
    cyc(1, 8'hEE);
    chk("R6 dropped: fill", int'(fill_count), 0);
    chk("R6 dropped: active", int'(active_slot), 0);
    peek(0, "R6 dropped: slot0 intact", 5'b00001, BB);
    peek_byte(0, 0, "R6 dropped: data intact", 'hA0);
    cyc(0, 0, .cl(1), .cs(0));
    peek(0, "R7 clear", 0, -1);
    cyc(1, 8'h55);
    peek(0, "R6 overrun carried", 5'b10000, -1);
    peek_byte(0, 0, "R6 accepted byte", 'h55);
  endtask

  task automatic t_errors;
    cyc(1, 8'h56, .p(1));
    cyc(1, 8'h57, .f(1));
    peek(0, "R5 error flags", 5'b11100, -1);
    chk("R5 fill", int'(fill_count), 3);
    cyc(1, 8'h58);
    peek(0, "R5 flags kept through close", 5'b11101, BB);
  endtask

  task automatic t_clear_vs_close;
    ctrl_word = '0;
    cyc(0, 0, .cl(1), .cs(0));
    cyc(0, 0, .cl(1), .cs(1));
    ctrl_word = mk_ctrl(0, 1, 0);
    cyc(1, 8'hC0, .p(1)); cyc(1, 8'hC1); cyc(1, 8'hC2);
    cyc(1, 8'hC3, .cl(1), .cs(0));
    peek(0, "R7 close wins over clear", 5'b00001, BB);
    chk("R1 count 0 means one buffer", int'(active_slot), 0);
    chk("R1 event slot", evt_last, 0);
  endtask

  task automatic t_abort;
    int e0;
    ctrl_word = '0;
    cyc(0, 0, .cl(1), .cs(0));
    ctrl_word = mk_ctrl(3, 1, 0);
    cyc(1, 8'hD0);
    ctrl_word = mk_ctrl(3, 1, 1);
    cyc(0, 0); cyc(0, 0);
    chk("R8 single abort pulse", ab_n, 1);
    e0 = evt_n;
    for (int i = 0; i < 5; i++) cyc(1, 8'hDD, .tk(1));
    chk("R8 bytes ignored", int'(fill_count), 1);
    chk("R8 no ready events", evt_n, e0);
    ctrl_word = '0;
    cyc(0, 0);
    chk("R9 disable clears fill", int'(fill_count), 0);
    cyc(1, 8'hEE);
    chk("R9 disabled byte ignored", int'(fill_count), 0);
    ctrl_word = mk_ctrl(3, 1, 0);
    cyc(1, 8'hD7);
    chk("R9 restart slot", int'(active_slot), 0);
    chk("R9 restart fill", int'(fill_count), 1);
    peek_byte(0, 0, "R9 restart byte", 'hD7);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog R1..all actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_full();
    t_idle();
    t_drop();
    t_errors();
    t_clear_vs_close();
    t_abort();
    finish_run();
  end
endmodule